// File: doc/BRIEF.md
# Inversion-Coded DC-Balance Word Encoder

This block codes one parallel word per cycle for one lane of an AC-coupled serial link. Each accepted word leaves as a 9-bit symbol: the 7 data bits, sent either as they are or with every bit inverted, followed by two complementary flag bits that tell the far end which choice was made. A signed running sum of the lane's transmitted ones and zeros decides the inversion at each word boundary. This keeps the line's low-frequency content bounded so that coupling capacitors do not drift.

A balance-enable input selects the coded mode. With balance off, the 7 data bits pass straight through with no flag bits and the running sum is held at zero. Every later enable therefore starts from a neutral line. The output is registered one cycle behind the accepted input. A matching combinational decoder ships alongside for checking round trips.

Top module: `dcb_word_encoder`

## Requirements
- R1: In coded mode the symbol carries the sent data in `out_sym[6:0]`, with bit 0 transmitted first, and the flags in `out_sym[8:7]` transmitted after the data. Flags `2'b10` mean the data is inverted and `2'b01` mean it is unchanged, so the two flag bits always differ.
- R2: The word is inverted exactly when the running sum and the word's disparity (ones minus zeros of the 7 input bits) are both nonzero and have the same sign. Otherwise it is sent unchanged.
- R3: After each coded word, `run_sum` grows by the ones-minus-zeros count of the whole 9-bit symbol. The flag pair contributes zero net.
- R4: At every word boundary `run_sum` lies within -7..+7. Walking the transmitted bits in order, the partial sum never leaves -10..+10.
- R5: When `bal_en` is 0, `out_sym[6:0]` equals the input word, `out_sym[8:7]` is `2'b00`, `out_coded` is 0, and `run_sum` is cleared to 0 at the next edge and held there.
- R6: While `rst_n` is low, `out_vld`, `out_coded`, `out_sym` and `run_sum` are all 0.
- R7: `out_vld` follows `in_vld` one clock later, and the symbol appears in that same cycle.
- R8: The decoder returns the original word from any symbol the encoder emits in either mode. It flags a coded symbol whose flag pair is `2'b00` or `2'b11` as malformed.
- R9: In a cycle with `in_vld` low, `run_sum` and `out_sym` keep their values and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bal_en | input | 1 | 1 selects coded 9-bit symbols, 0 selects plain 7-bit bypass |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 7 | Parallel data word |
| out_vld | output | 1 | Symbol on `out_sym` is new this cycle |
| out_coded | output | 1 | 1 when `out_sym` holds a 9-bit coded symbol |
| out_sym | output | 9 | Data in bits 6:0, flag pair in bits 8:7 |
| run_sum | output | 6 | Signed lane running sum at the word boundary |

## Verification
The bound checker watches every cycle for several properties: complementary flags on coded symbols, inverted data matching the previous input word, the boundary sum staying inside ±7, the sum moving toward zero whenever it was nonzero, the clear in bypass, the hold on idle cycles, and the one-cycle valid latency. Only the bench scenarios can show that each exact symbol value is right, and that the bit-by-bit partial sum inside a symbol stays within ±10 under long worst-case runs of all-ones and all-zeros words. The same holds for the decoder round trip and for malformed flag pairs being reported.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

   // Flag pair carried in the two most significant symbol bits
   typedef enum logic [1:0] {
      FLAG_NONE  = 2'b00,
      FLAG_PLAIN = 2'b01,
      FLAG_INV   = 2'b10,
      FLAG_BOTH  = 2'b11
   } dcb_flag_e;

endpackage

// File: rtl/dcb_ones_count.sv
module dcb_ones_count #(
   parameter int VEC_W = 7,
   localparam int CNT_W = $clog2(VEC_W + 1)
) (
   input  logic [VEC_W-1:0] vec,
   output logic [CNT_W-1:0] cnt
);

   always_comb begin
      cnt = '0;
      for (int i = 0; i < VEC_W; i++) begin
         cnt = cnt + CNT_W'(vec[i]);
      end
   end

endmodule

// File: rtl/dcb_inv_decide.sv
module dcb_inv_decide #(
   parameter int WORD_W = 7,
   parameter int SUM_W  = 6
) (
   input  logic                    [WORD_W-1:0] word,
   input  logic signed             [SUM_W-1:0]  cur_sum,
   output logic                                 invert,
   output logic signed             [SUM_W-1:0]  sent_disp
);

   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic signed [SUM_W-1:0] WORD_S = SUM_W'(WORD_W);

   logic [CNT_W-1:0]        ones;
   logic signed [SUM_W-1:0] word_disp;
   logic                    disp_pos;
   logic                    sum_pos;
   logic                    sum_neg;

   dcb_ones_count #(.VEC_W(WORD_W)) u_cnt (
      .vec (word),
      .cnt (ones)
   );

   always_comb begin
      // disparity = 2*ones - width; never zero for an odd width
      word_disp = $signed({{(SUM_W - CNT_W - 1){1'b0}}, ones, 1'b0}) - WORD_S;
      disp_pos  = ~word_disp[SUM_W-1];
      sum_neg   = cur_sum[SUM_W-1];
      sum_pos   = ~cur_sum[SUM_W-1] && (cur_sum != '0);
      invert    = (sum_pos && disp_pos) || (sum_neg && !disp_pos);
      sent_disp = invert ? -word_disp : word_disp;
   end

endmodule

// File: rtl/dcb_sum_reg.sv
module dcb_sum_reg #(
   parameter int SUM_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    upd,
   input  logic signed [SUM_W-1:0] delta,
   output logic signed [SUM_W-1:0] sum
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (clear) begin
         sum <= '0;
      end else if (upd) begin
         sum <= sum + delta;
      end
   end

endmodule

// File: rtl/dcb_word_encoder.sv
module dcb_word_encoder #(
   parameter int WORD_W  = 7,
   parameter int SUM_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bal_en,
   input  logic                     in_vld,
   input  logic [WORD_W-1:0]        in_word,
   output logic                     out_vld,
   output logic                     out_coded,
   output logic [WORD_W+1:0]        out_sym,
   output logic signed [SUM_W-1:0]  run_sum
);

   import dcb_pkg::*;

   localparam int SYM_W = WORD_W + 2;
   localparam int CNT_W = $clog2(WORD_W + 1);

   // elaboration-time parameter checks
   if (WORD_W % 2 == 0) begin : g_bad_width
      $error("dcb_word_encoder: WORD_W must be odd so disparity is never zero");
   end
   if (WORD_W < 3) begin : g_bad_small
      $error("dcb_word_encoder: WORD_W must be at least 3");
   end
   if (SUM_W < CNT_W + 2) begin : g_bad_sum
      $error("dcb_word_encoder: SUM_W too narrow for the boundary sum range");
   end

   logic                    inv;
   logic signed [SUM_W-1:0] delta;
   logic [SYM_W-1:0]        sym_nxt;
   dcb_flag_e               flag_nxt;

   dcb_inv_decide #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_decide (
      .word      (in_word),
      .cur_sum   (run_sum),
      .invert    (inv),
      .sent_disp (delta)
   );

   dcb_sum_reg #(.SUM_W(SUM_W)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~bal_en),
      .upd   (in_vld & bal_en),
      .delta (delta),
      .sum   (run_sum)
   );

   always_comb begin
      flag_nxt = inv ? FLAG_INV : FLAG_PLAIN;
      if (bal_en) begin
         sym_nxt = {flag_nxt, (inv ? ~in_word : in_word)};
      end else begin
         sym_nxt = {FLAG_NONE, in_word};
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld   <= 1'b0;
            out_coded <= 1'b0;
            out_sym   <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               out_coded <= bal_en;
               out_sym   <= sym_nxt;
            end
         end
      end
   end else begin : g_out_comb
      always_comb begin
         out_vld   = in_vld;
         out_coded = bal_en;
         out_sym   = sym_nxt;
      end
   end

endmodule

// File: rtl/dcb_enc_chk.sv
module dcb_enc_chk #(
   parameter int WORD_W  = 7,
   parameter int SUM_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bal_en,
   input logic                    in_vld,
   input logic [WORD_W-1:0]       in_word,
   input logic                    out_vld,
   input logic                    out_coded,
   input logic [WORD_W+1:0]       out_sym,
   input logic signed [SUM_W-1:0] run_sum
);

   localparam logic signed [SUM_W-1:0] LIM = SUM_W'(WORD_W);

   // R1
   flags_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_coded) |-> (out_sym[WORD_W+1] ^ out_sym[WORD_W]));

   // R4
   sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_sum <= LIM) && (run_sum >= -LIM));

   // R2
   sum_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && bal_en && !run_sum[SUM_W-1] && run_sum != '0) |=> (run_sum < $past(run_sum)));

   // R2
   sum_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && bal_en && run_sum[SUM_W-1]) |=> (run_sum > $past(run_sum)));

   // R5
   bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bal_en |=> (run_sum == '0));

   // R5
   bypass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_coded) |-> (out_sym[WORD_W+1:WORD_W] == 2'b00));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_vld && bal_en) |=> $stable(run_sum));

   if (OUT_REG) begin : g_reg_chk
      // R7
      vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);

      // R9
      idle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> (!out_vld && $stable(out_sym)));

      // R1
      inv_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && bal_en) |=> (out_sym[WORD_W+1] ? (out_sym[WORD_W-1:0] == ~$past(in_word))
                                                   : (out_sym[WORD_W-1:0] == $past(in_word))));
   end

endmodule

bind dcb_word_encoder dcb_enc_chk #(
   .WORD_W  (WORD_W),
   .SUM_W   (SUM_W),
   .OUT_REG (OUT_REG)
) u_enc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bal_en    (bal_en),
   .in_vld    (in_vld),
   .in_word   (in_word),
   .out_vld   (out_vld),
   .out_coded (out_coded),
   .out_sym   (out_sym),
   .run_sum   (run_sum)
);

// File: tb/dcb_word_decoder.sv
module dcb_word_decoder #(
   parameter int WORD_W = 7
) (
   input  logic              coded,
   input  logic [WORD_W+1:0] sym,
   output logic [WORD_W-1:0] word,
   output logic              flags_ok
);

   logic [1:0] pair;

   always_comb begin
      pair = sym[WORD_W+1:WORD_W];
      if (!coded) begin
         word     = sym[WORD_W-1:0];
         flags_ok = 1'b1;
      end else begin
         flags_ok = pair[1] ^ pair[0];
         word     = (pair == 2'b10) ? ~sym[WORD_W-1:0] : sym[WORD_W-1:0];
      end
   end

endmodule

// File: tb/test_dcb_word_encoder.sv
module test_dcb_word_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int W = 7;
   localparam int SW = 6;

   typedef struct packed {
      logic             bal;
      logic [W-1:0]     word;
      logic [W+1:0]     sym;
      logic             coded;
      logic signed [7:0] sum;
   } vec_t;

   // Hand-derived from R1..R5, starting at sum 0 after reset
   localparam vec_t TAB [12] = '{
      '{1'b1, 7'h7F, 9'h0FF, 1'b1,  8'sd7},
      '{1'b1, 7'h7F, 9'h100, 1'b1,  8'sd0},
      '{1'b1, 7'h00, 9'h080, 1'b1, -8'sd7},
      '{1'b1, 7'h00, 9'h17F, 1'b1,  8'sd0},
      '{1'b1, 7'h07, 9'h087, 1'b1, -8'sd1},
      '{1'b1, 7'h0F, 9'h08F, 1'b1,  8'sd0},
      '{1'b1, 7'h01, 9'h081, 1'b1, -8'sd5},
      '{1'b1, 7'h03, 9'h17C, 1'b1, -8'sd2},
      '{1'b1, 7'h55, 9'h0D5, 1'b1, -8'sd1},
      '{1'b0, 7'h7F, 9'h07F, 1'b0,  8'sd0},
      '{1'b1, 7'h3F, 9'h0BF, 1'b1,  8'sd5},
      '{1'b1, 7'h3E, 9'h141, 1'b1,  8'sd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bal_en = 1'b1;
   logic in_vld = 1'b0;
   logic [W-1:0] in_word = '0;
   logic out_vld;
   logic out_coded;
   logic [W+1:0] out_sym;
   logic signed [SW-1:0] run_sum;

   logic dec_coded = 1'b1;
   logic [W+1:0] dec_sym = '0;
   logic [W-1:0] dec_word;
   logic dec_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dcb_word_encoder i_dcb_word_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .bal_en    (bal_en),
      .in_vld    (in_vld),
      .in_word   (in_word),
      .out_vld   (out_vld),
      .out_coded (out_coded),
      .out_sym   (out_sym),
      .run_sum   (run_sum)
   );

   dcb_word_decoder #(.WORD_W(W)) i_dec (
      .coded    (dec_coded),
      .sym      (dec_sym),
      .word     (dec_word),
      .flags_ok (dec_ok)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one word; returns after the capturing edge
   task automatic apply(input logic bal, input logic [W-1:0] w);
      @(negedge clk);
      bal_en  = bal;
      in_vld  = 1'b1;
      in_word = w;
      @(posedge clk);
      #1;
      in_vld = 1'b0;
   endtask

   initial begin
      int m_sum;
      int part;
      int worst;
      int d;
      bit inv;
      logic [W-1:0] w;
      logic [W+1:0] exp_sym;
      logic signed [SW-1:0] held;

      // reset state, R6
      repeat (3) @(posedge clk);
      #1;
      chk(out_vld == 1'b0 && out_coded == 1'b0, "R6 reset valid/coded", out_vld, 0);
      chk(out_sym == '0, "R6 reset symbol", out_sym, 0);
      chk(run_sum == '0, "R6 reset sum", run_sum, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk, R1 R2 R3 R5 R7
      for (int i = 0; i < 12; i++) begin
         apply(TAB[i].bal, TAB[i].word);
         chk(out_vld == 1'b1, "R7 valid one cycle later", out_vld, 1);
         chk(out_sym == TAB[i].sym, "R1/R2 table symbol", out_sym, TAB[i].sym);
         chk(out_coded == TAB[i].coded, "R5 coded flag", out_coded, TAB[i].coded);
         chk(run_sum == SW'(TAB[i].sum), "R3 table running sum", run_sum, TAB[i].sum);
      end

      // R9: idle cycles hold sum and symbol, valid drops
      held = run_sum;
      exp_sym = out_sym;
      @(negedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "R9 idle valid low", out_vld, 0);
      chk(run_sum == held, "R9 idle sum held", run_sum, held);
      chk(out_sym == exp_sym, "R9 idle symbol held", out_sym, exp_sym);

      // R5: bypass clears a nonzero sum, re-enable starts at zero
      apply(1'b1, 7'h7F);
      apply(1'b0, 7'h2A);
      chk(run_sum == '0, "R5 bypass clears sum", run_sum, 0);
      chk(out_sym == 9'h02A, "R5 bypass passes word", out_sym, 9'h02A);
      apply(1'b1, 7'h7F);
      chk(out_sym == 9'h0FF, "R5 re-enable starts neutral", out_sym, 9'h0FF);
      chk(run_sum == 7, "R5 sum after re-enable", run_sum, 7);

      // R6: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(run_sum == '0 && out_vld == 1'b0 && out_sym == '0, "R6 mid-run reset", run_sum, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: malformed flag pairs
      dec_coded = 1'b1;
      dec_sym = 9'h000;
      #1;
      chk(dec_ok == 1'b0, "R8 flags 00 malformed", dec_ok, 0);
      dec_sym = 9'h180;
      #1;
      chk(dec_ok == 1'b0, "R8 flags 11 malformed", dec_ok, 0);

      // random and worst-case run: R2 R3 R4 R8 against a requirement model
      m_sum = 0;
      worst = 0;
      for (int n = 0; n < 3000; n++) begin
         case (n % 11)
            3: w = 7'h7F;
            4: w = 7'h7F;
            7: w = 7'h00;
            8: w = 7'h01;
            9: w = 7'h7E;
            default: w = W'($urandom);
         endcase
         d = 2 * $countones(w) - W;
         inv = (m_sum > 0 && d > 0) || (m_sum < 0 && d < 0);
         exp_sym = inv ? {2'b10, ~w} : {2'b01, w};
         apply(1'b1, w);
         chk(out_sym == exp_sym, "R2 random symbol", out_sym, exp_sym);
         part = m_sum;
         for (int b = 0; b < W + 2; b++) begin
            part += out_sym[b] ? 1 : -1;
            if (part > worst) worst = part;
            if (-part > worst) worst = -part;
         end
         m_sum += inv ? -d : d;
         chk(run_sum == SW'(m_sum), "R3 random sum", run_sum, m_sum);
         chk(m_sum <= 7 && m_sum >= -7, "R4 boundary sum", m_sum, 7);
         dec_coded = out_coded;
         dec_sym = out_sym;
         #1;
         chk(dec_word == w && dec_ok, "R8 round trip", dec_word, w);
      end
      chk(worst <= 10, "R4 bit-level sum within 10", worst, 10);

      // R8 bypass round trip
      apply(1'b0, 7'h5B);
      dec_coded = out_coded;
      dec_sym = out_sym;
      #1;
      chk(dec_word == 7'h5B && dec_ok, "R8 bypass round trip", dec_word, 7'h5B);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule